// File: doc/BRIEF.md
# Sixteen-Bit Compare Timer with PWM and Single-Shot Output

The block is a 16-bit up-counter with two compare channels, two capture inputs and an output waveform generator. Everything runs on the CPU clock. The counter advances by one on each count tick. Ticks come either from an internal prescaler (divide by 2, 4 or 8) or from edges of an external clock pin. That pin is first synchronized to the CPU clock, and only the edge polarity chosen in the control register produces a tick.

The waveform on compare output 1 depends on the mode held in the control register. In the plain mode the counter free-runs, and each compare output toggles when the counter matches its compare value. In PWM mode, compare value 2 sets the period and compare value 1 sets the high time. In single-shot mode, a selected edge on capture pin 1 starts one high pulse whose length is set by compare value 1. A controller (FSM) with five states drives these modes: `ST_FREE`, `ST_PWM_HI`, `ST_PWM_LO`, `ST_OPM_IDLE` and `ST_OPM_PULSE`.

The FSM transitions are as follows:
- A mode change moves the FSM from any state to the entry state of the new mode. Entering PWM goes to `ST_PWM_HI` and restarts the counter. Entering single-shot goes to `ST_OPM_IDLE`. Leaving both modes goes to `ST_FREE`.
- In PWM, a match on compare 2 restarts the counter and goes to `ST_PWM_HI`. A match on compare 1 goes from `ST_PWM_HI` to `ST_PWM_LO`.
- A trigger edge moves `ST_OPM_IDLE` to `ST_OPM_PULSE`. A match on compare 1 returns the FSM to `ST_OPM_IDLE`.

Software writes registers through `wr_en`, `wr_sel` and `wr_data`. The select codes are:
- `wr_sel` 0: control byte, taken from `wr_data[7:0]`.
- `wr_sel` 1: compare value 1.
- `wr_sel` 2: compare value 2.
- `wr_sel` 3: ignored.

Top module: `pulse_timer16`

## Requirements
- R1: After reset the following are all zero: the control byte, the counter, both captures, both flags and all compare outputs and enables. A write with `wr_sel` 0, 1 or 2 loads the control byte, compare 1 or compare 2.
- R2: Control bits [3:2] select the tick source. The code 00 gives one tick every 4 CPU clocks, 01 gives one every 2, and 10 gives one every 8. The counter gains exactly one per tick.
- R3: Code 11 in bits [3:2] takes ticks from `ext_clk`. Control bit 0 selects the edge: 1 counts rising edges and 0 counts falling edges. The other edge does not count.
- R4: Control bit 1 selects the edge on `cap2_pin` that copies the counter into `cap2_val`: 1 means rising and 0 means falling. The other edge leaves `cap2_val` unchanged. Input `cap1_rise` selects the edge for `cap1_pin` and `cap1_val` in the same way.
- R5: Control bit 7 drives `cmp1_oe` and control bit 6 drives `cmp2_oe`. While an enable is 0, its compare output is held at 0.
- R6: With control bit 4 set, `cmp1_out` repeats a pattern. It is high for (compare1+1) ticks and low for (compare2-compare1) ticks. The counter restarts at 0 after it matches compare 2.
- R7: In PWM mode with compare1 >= compare2, `cmp1_out` stays high continuously.
- R8: With control bit 5 set and bit 4 clear, the selected edge on `cap1_pin` restarts the counter and the prescaler. `cmp1_out` then goes high for exactly (compare1+1) ticks.
- R9: While a single-shot pulse is high, further trigger edges on `cap1_pin` are ignored. The pulse length is unchanged.
- R10: When bits 4 and 5 are both set, PWM behaviour applies.
- R11: `cmp_flag[x]` sets when a tick arrives while the counter equals compare value x+1. The flag then holds until the matching `flag_clr` bit is raised.
- R12: In the plain mode, each compare output toggles on its own channel match. The counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 compare 1, 2 compare 2 |
| wr_data | input | 16 | Write data |
| flag_clr | input | 2 | Per-channel match flag clear |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap1_pin | input | 1 | Capture pin 1, also the single-shot trigger |
| cap1_rise | input | 1 | Edge select for capture pin 1 (1 = rising) |
| cap2_pin | input | 1 | Capture pin 2 |
| cmp1_out | output | 1 | Compare output 1 / waveform |
| cmp1_oe | output | 1 | Compare output 1 owned by the timer |
| cmp2_out | output | 1 | Compare output 2 |
| cmp2_oe | output | 1 | Compare output 2 owned by the timer |
| cnt_val | output | 16 | Current counter value |
| cap1_val | output | 16 | Capture value 1 |
| cap2_val | output | 16 | Capture value 2 |
| cmp_flag | output | 2 | Match flags, bit 0 for channel 1 |

## Verification
The tick source is tried with all three divisor codes, each over a window of eight tick periods. This shows each code gives its own rate and not a neighbour's. The external clock is driven with both polarity settings, and a frozen counter lets a capture be compared against an exact value. Each capture pin is tried with the edge that should latch and the edge that should not.

PWM is run in three settings:
- High time shorter than the period, which separates the roles of the two compare values.
- Equal compare values, which shows the full-duty corner.
- Both mode bits set, which exposes the priority between the modes.

Single-shot is run with a clean trigger and again with a second trigger inside the pulse, which shows whether a pulse can be restarted.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_PWM_HI,
        ST_PWM_LO,
        ST_OPM_IDLE,
        ST_OPM_PULSE
    } ptmr_state_e;

    typedef struct packed {
        logic       oc1_en;
        logic       oc2_en;
        logic       one_shot;
        logic       pwm_on;
        logic [1:0] clk_sel;
        logic       cap2_rise;
        logic       ext_rise;
    } ptmr_ctrl_t;

    localparam logic [1:0] CS_DIV4 = 2'b00;
    localparam logic [1:0] CS_DIV2 = 2'b01;
    localparam logic [1:0] CS_DIV8 = 2'b10;
    localparam logic [1:0] CS_EXT  = 2'b11;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CMP1 = 2'd1;
    localparam logic [1:0] SEL_CMP2 = 2'd2;

endpackage

// File: rtl/ptmr_sync_edge.sv
module ptmr_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[DEPTH-2:0], pin_i};
        end
    end

    logic now_lvl, old_lvl;
    assign now_lvl = shift_q[SYNC_STAGES-1];
    assign old_lvl = shift_q[SYNC_STAGES];

    always_comb begin
        if (rise_sel_i) edge_o = now_lvl & ~old_lvl;
        else            edge_o = ~now_lvl & old_lvl;
    end
endmodule

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen
    import ptmr_pkg::*;
#(
    parameter int DIV_QUARTER = 4,
    parameter int DIV_HALF    = 2,
    parameter int DIV_EIGHTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel_i,
    input  logic       phase_rst_i,
    input  logic       ext_pin_i,
    input  logic       ext_rise_i,
    output logic       tick_o
);
    localparam int DIV_MAX = (DIV_EIGHTH > DIV_QUARTER) ?
                             ((DIV_EIGHTH > DIV_HALF) ? DIV_EIGHTH : DIV_HALF) :
                             ((DIV_QUARTER > DIV_HALF) ? DIV_QUARTER : DIV_HALF);
    localparam int DIV_W = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic [DIV_W-1:0] LIM_Q = DIV_W'(DIV_QUARTER - 1);
    localparam logic [DIV_W-1:0] LIM_H = DIV_W'(DIV_HALF - 1);
    localparam logic [DIV_W-1:0] LIM_E = DIV_W'(DIV_EIGHTH - 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;
    logic             ext_edge;
    logic             use_ext;

    ptmr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin_i),
        .rise_sel_i (ext_rise_i),
        .edge_o     (ext_edge)
    );

    always_comb begin
        use_ext = 1'b0;
        limit   = LIM_Q;
        unique case (clk_sel_i)
            CS_DIV4: limit = LIM_Q;
            CS_DIV2: limit = LIM_H;
            CS_DIV8: limit = LIM_E;
            CS_EXT:  use_ext = 1'b1;
        endcase
    end

    assign tick_o = use_ext ? ext_edge : (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (phase_rst_i || use_ext || (div_q == limit)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/ptmr_mode_fsm.sv
module ptmr_mode_fsm
    import ptmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          pwm_i,
    input  logic          opm_i,
    input  logic          trig_i,
    input  logic [CW-1:0] cmp1_i,
    input  logic [CW-1:0] cmp2_i,
    output logic [CW-1:0] cnt_o,
    output ptmr_state_e   state_o,
    output logic          wave_o,
    output logic          wave_sel_o,
    output logic          restart_o
);
    ptmr_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = tick_i ? (cnt_q + CW'(1)) : cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FREE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and counter
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_inc;
        restart_o = 1'b0;
        unique case (st_q)
            ST_FREE: begin
                if (pwm_i) begin
                    st_d = ST_PWM_HI; cnt_d = '0; restart_o = 1'b1;
                end else if (opm_i) begin
                    st_d = ST_OPM_IDLE;
                end
            end
            ST_PWM_HI: begin
                if (!pwm_i) begin
                    st_d = opm_i ? ST_OPM_IDLE : ST_FREE;
                end else if (tick_i && cnt_q == cmp2_i) begin
                    cnt_d = '0;
                end else if (tick_i && cnt_q == cmp1_i) begin
                    st_d = ST_PWM_LO;
                end
            end
            ST_PWM_LO: begin
                if (!pwm_i) begin
                    st_d = opm_i ? ST_OPM_IDLE : ST_FREE;
                end else if (tick_i && cnt_q == cmp2_i) begin
                    st_d = ST_PWM_HI; cnt_d = '0;
                end
            end
            ST_OPM_IDLE: begin
                if (pwm_i) begin
                    st_d = ST_PWM_HI; cnt_d = '0; restart_o = 1'b1;
                end else if (!opm_i) begin
                    st_d = ST_FREE;
                end else if (trig_i) begin
                    st_d = ST_OPM_PULSE; cnt_d = '0; restart_o = 1'b1;
                end
            end
            ST_OPM_PULSE: begin
                if (pwm_i) begin
                    st_d = ST_PWM_HI; cnt_d = '0; restart_o = 1'b1;
                end else if (!opm_i) begin
                    st_d = ST_FREE;
                end else if (tick_i && cnt_q == cmp1_i) begin
                    st_d = ST_OPM_IDLE;
                end
            end
            default: st_d = ST_FREE;
        endcase
    end

    // Outputs
    always_comb begin
        wave_o     = (st_q == ST_PWM_HI) || (st_q == ST_OPM_PULSE);
        wave_sel_o = (st_q != ST_FREE);
        cnt_o      = cnt_q;
        state_o    = st_q;
    end
endmodule

// File: rtl/pulse_timer16.sv
module pulse_timer16
    import ptmr_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    flag_clr,
    input  logic          ext_clk,
    input  logic          cap1_pin,
    input  logic          cap1_rise,
    input  logic          cap2_pin,
    output logic          cmp1_out,
    output logic          cmp1_oe,
    output logic          cmp2_out,
    output logic          cmp2_oe,
    output logic [CW-1:0] cnt_val,
    output logic [CW-1:0] cap1_val,
    output logic [CW-1:0] cap2_val,
    output logic [1:0]    cmp_flag
);
    localparam int NCH = 2;

    ptmr_ctrl_t    ctrl_q;
    logic [CW-1:0] cmp1_q, cmp2_q;
    logic          ctrl_wr;
    logic          cnt_tick;
    logic          fsm_restart;
    logic          wave1, wave_sel;
    ptmr_state_e   fsm_state;
    logic [CW-1:0] cnt_q;

    logic [NCH-1:0]         cap_pins, cap_rise_sel, cap_edge, match, flag_bus, tgl_bus;
    logic [NCH-1:0][CW-1:0] cmp_bus, cap_bus;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp1_q <= '0;
            cmp2_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_CTRL: ctrl_q <= ptmr_ctrl_t'(wr_data[7:0]);
                SEL_CMP1: cmp1_q <= wr_data;
                SEL_CMP2: cmp2_q <= wr_data;
                default:  ;
            endcase
        end
    end

    ptmr_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_sel_i   (ctrl_q.clk_sel),
        .phase_rst_i (fsm_restart | ctrl_wr),
        .ext_pin_i   (ext_clk),
        .ext_rise_i  (ctrl_q.ext_rise),
        .tick_o      (cnt_tick)
    );

    assign cap_pins     = {cap2_pin, cap1_pin};
    assign cap_rise_sel = {ctrl_q.cap2_rise, cap1_rise};
    assign cmp_bus      = {cmp2_q, cmp1_q};

    ptmr_mode_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (cnt_tick),
        .pwm_i      (ctrl_q.pwm_on),
        .opm_i      (ctrl_q.one_shot),
        .trig_i     (cap_edge[0]),
        .cmp1_i     (cmp1_q),
        .cmp2_i     (cmp2_q),
        .cnt_o      (cnt_q),
        .state_o    (fsm_state),
        .wave_o     (wave1),
        .wave_sel_o (wave_sel),
        .restart_o  (fsm_restart)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [CW-1:0] cap_r;
        logic          flag_r;
        logic          tgl_r;

        ptmr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cap_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (cap_pins[g]),
            .rise_sel_i (cap_rise_sel[g]),
            .edge_o     (cap_edge[g])
        );

        assign match[g] = cnt_tick && (cnt_q == cmp_bus[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_r  <= '0;
                flag_r <= 1'b0;
                tgl_r  <= 1'b0;
            end else begin
                if (cap_edge[g]) cap_r <= cnt_q;
                flag_r <= match[g] | (flag_r & ~flag_clr[g]);
                if (match[g]) tgl_r <= ~tgl_r;
            end
        end

        assign cap_bus[g]  = cap_r;
        assign flag_bus[g] = flag_r;
        assign tgl_bus[g]  = tgl_r;
    end

    assign cmp1_oe  = ctrl_q.oc1_en;
    assign cmp2_oe  = ctrl_q.oc2_en;
    assign cmp1_out = ctrl_q.oc1_en & (wave_sel ? wave1 : tgl_bus[0]);
    assign cmp2_out = ctrl_q.oc2_en & tgl_bus[1];
    assign cnt_val  = cnt_q;
    assign cap1_val = cap_bus[0];
    assign cap2_val = cap_bus[1];
    assign cmp_flag = flag_bus;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
    import ptmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input ptmr_state_e   st,
    input logic [CW-1:0] cnt,
    input logic          tick,
    input logic [CW-1:0] cmp1,
    input logic [CW-1:0] cmp2,
    input logic          pwm_bit,
    input logic          opm_bit,
    input logic          wr_en,
    input logic          out1,
    input logic          oe1,
    input logic          out2,
    input logic          oe2,
    input logic [1:0]    flags,
    input logic [1:0]    clr
);
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == '0 && flags == 2'b00 && !out1 && !out2));

    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe1 |-> !out1) and (!oe2 |-> !out2));

    a_r6_pwm_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PWM_HI || st == ST_PWM_LO) && pwm_bit && tick && cnt == cmp2)
        |=> (cnt == '0 && st == ST_PWM_HI));

    a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPM_PULSE && opm_bit && !pwm_bit && !tick && !wr_en)
        |=> ($stable(cnt) && st == ST_OPM_PULSE));

    a_r10_pwm_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_bit && opm_bit && !wr_en) |=> (st == ST_PWM_HI || st == ST_PWM_LO));

    a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !clr[0]) |=> flags[0]);

    a_r12_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FREE && !pwm_bit && !opm_bit && tick && cnt == '1) |=> (cnt == '0));

    a_r12_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FREE && !pwm_bit && !opm_bit && !tick) |=> $stable(cnt));
endmodule

bind pulse_timer16 ptmr_checker #(.CW(CW)) u_ptmr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (fsm_state),
    .cnt     (cnt_q),
    .tick    (cnt_tick),
    .cmp1    (cmp1_q),
    .cmp2    (cmp2_q),
    .pwm_bit (ctrl_q.pwm_on),
    .opm_bit (ctrl_q.one_shot),
    .wr_en   (wr_en),
    .out1    (cmp1_out),
    .oe1     (cmp1_oe),
    .out2    (cmp2_out),
    .oe2     (cmp2_oe),
    .flags   (cmp_flag),
    .clr     (flag_clr)
);

// File: tb/test_pulse_timer16.sv
module test_pulse_timer16;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [CW-1:0] wr_data = '0;
    logic [1:0]    flag_clr = '0;
    logic          ext_clk = 1'b0;
    logic          cap1_pin = 1'b0;
    logic          cap1_rise = 1'b0;
    logic          cap2_pin = 1'b0;
    logic          cmp1_out, cmp1_oe, cmp2_out, cmp2_oe;
    logic [CW-1:0] cnt_val, cap1_val, cap2_val;
    logic [1:0]    cmp_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        int    val;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_timer16 i_pulse_timer16 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_clr(flag_clr), .ext_clk(ext_clk), .cap1_pin(cap1_pin), .cap1_rise(cap1_rise),
        .cap2_pin(cap2_pin), .cmp1_out(cmp1_out), .cmp1_oe(cmp1_oe), .cmp2_out(cmp2_out),
        .cmp2_oe(cmp2_oe), .cnt_val(cnt_val), .cap1_val(cap1_val), .cap2_val(cap2_val),
        .cmp_flag(cmp_flag)
    );

    // Driver side: expected item and observed item go to separate queues
    task automatic push_check(input string req, input int expv, input int actv);
        item_t e, a;
        e.req = req; e.val = expv;
        a.req = req; a.val = actv;
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    // Monitor: pops and compares
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (e.val != a.val) begin
                failures++;
                $display("FAIL %s actual=%0d expected=%0d", e.req, a.val, e.val);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [CW-1:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rate_check(input string req, input logic [1:0] code, input int div);
        int a, b;
        write_reg(2'd0, CW'({code, 2'b00}));
        cycles(20);
        @(negedge clk); a = cnt_val;
        repeat (8 * div) @(negedge clk);
        b = cnt_val;
        push_check(req, 8, (b - a) & 16'hFFFF);
    endtask

    task automatic ext_pulse();
        ext_clk = 1'b1; cycles(5);
        ext_clk = 1'b0; cycles(5);
    endtask

    task automatic measure_wave(output int hi, output int lo);
        int g;
        g = 0;
        @(negedge clk);
        while (cmp1_out !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
        while (cmp1_out !== 1'b1 && g < 8000) begin @(negedge clk); g++; end
        hi = 0;
        while (cmp1_out === 1'b1 && hi < 4000) begin @(negedge clk); hi++; end
        lo = 0;
        while (cmp1_out === 1'b0 && lo < 4000) begin @(negedge clk); lo++; end
    endtask

    task automatic measure_high(output int hi);
        int g;
        g = 0;
        @(negedge clk);
        while (cmp1_out !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
        hi = 0;
        while (cmp1_out === 1'b1 && hi < 4000) begin @(negedge clk); hi++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int a, b, hi, lo, prev2;

        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        push_check("R1 counter", 0, cnt_val);
        push_check("R1 flags", 0, cmp_flag);
        push_check("R1 outputs", 0, {cmp1_out, cmp1_oe, cmp2_out, cmp2_oe});
        push_check("R1 captures", 0, cap1_val | cap2_val);

        // R2: prescaler rates
        rate_check("R2 div4", 2'b00, 4);
        rate_check("R2 div2", 2'b01, 2);
        rate_check("R2 div8", 2'b10, 8);

        // R3: external clock, rising then falling
        write_reg(2'd0, 16'h000D);
        cycles(6);
        @(negedge clk); a = cnt_val;
        repeat (3) ext_pulse();
        cycles(4);
        @(negedge clk); b = cnt_val;
        push_check("R3 ext rising count", 3, (b - a) & 16'hFFFF);
        write_reg(2'd0, 16'h000C);
        cycles(6);
        @(negedge clk); a = cnt_val;
        repeat (2) ext_pulse();
        cycles(4);
        @(negedge clk); b = cnt_val;
        push_check("R3 ext falling count", 2, (b - a) & 16'hFFFF);

        // R4: capture with a frozen counter (ext mode, pin idle)
        write_reg(2'd0, 16'h000E);
        cycles(4);
        @(negedge clk); a = cnt_val;
        cap2_pin = 1'b1; cycles(5);
        cap2_pin = 1'b0; cycles(5);
        @(negedge clk);
        push_check("R4 cap2 rising latch", a, cap2_val);
        write_reg(2'd0, 16'h000C);
        ext_pulse();
        cycles(4);
        cap2_pin = 1'b1; cycles(6);
        @(negedge clk);
        push_check("R4 cap2 ignores rising when bit1=0", a, cap2_val);
        cap2_pin = 1'b0; cycles(6);
        @(negedge clk);
        push_check("R4 cap2 falling latch", (a + 1) & 16'hFFFF, cap2_val);
        cap1_rise = 1'b0;
        cap1_pin = 1'b1; cycles(5);
        cap1_pin = 1'b0; cycles(6);
        @(negedge clk);
        push_check("R4 cap1 falling latch", cnt_val, cap1_val);

        // R5: output enables
        write_reg(2'd0, 16'h00C0);
        cycles(2);
        @(negedge clk);
        push_check("R5 enables on", 3, {cmp1_oe, cmp2_oe});
        write_reg(2'd0, 16'h0000);
        cycles(2);
        @(negedge clk);
        push_check("R5 enables off", 0, {cmp1_oe, cmp2_oe});
        push_check("R5 outputs held low", 0, {cmp1_out, cmp2_out});

        // R6: PWM, width 3, period 9, divide by 2
        write_reg(2'd1, 16'd3);
        write_reg(2'd2, 16'd9);
        write_reg(2'd0, 16'h0094);
        measure_wave(hi, lo);
        push_check("R6 pwm high cycles", 8, hi);
        push_check("R6 pwm low cycles", 12, lo);

        // R7: compare1 equal to compare2 gives full duty
        write_reg(2'd1, 16'd9);
        cycles(30);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cmp1_out === 1'b1) hi++;
        end
        push_check("R7 full duty samples", 40, hi);

        // R8: single-shot, width 4, divide by 2
        write_reg(2'd0, 16'h0000);
        write_reg(2'd1, 16'd4);
        cap1_rise = 1'b1;
        cap1_pin = 1'b0;
        write_reg(2'd0, 16'h00A4);
        cycles(6);
        fork
            measure_high(hi);
            begin cycles(2); cap1_pin = 1'b1; end
        join
        push_check("R8 single pulse cycles", 10, hi);

        // R9: retrigger inside pulse is ignored
        write_reg(2'd1, 16'd9);
        cap1_pin = 1'b0;
        cycles(6);
        fork
            measure_high(hi);
            begin
                cycles(2); cap1_pin = 1'b1;
                cycles(9); cap1_pin = 1'b0;
                cycles(3); cap1_pin = 1'b1;
            end
        join
        push_check("R9 retrigger ignored cycles", 20, hi);

        // R10: both mode bits set
        write_reg(2'd1, 16'd3);
        write_reg(2'd2, 16'd9);
        write_reg(2'd0, 16'h00B4);
        measure_wave(hi, lo);
        push_check("R10 priority high cycles", 8, hi);
        push_check("R10 priority low cycles", 12, lo);

        // R11 / R12: flags and toggling in plain mode
        write_reg(2'd1, 16'd200);
        write_reg(2'd2, 16'd300);
        write_reg(2'd0, 16'h0000);
        write_reg(2'd0, 16'h0044);
        cycles(2);
        flag_clr = 2'b11; cycles(1); flag_clr = 2'b00;
        @(negedge clk);
        if (cnt_val > 16'd150) begin
            a = 0;
            while (cnt_val != 16'd0 && a < 140000) begin @(negedge clk); a++; end
        end
        @(negedge clk);
        push_check("R11 flags clear before match", 0, cmp_flag);
        prev2 = cmp2_out;
        a = 0;
        while (cnt_val <= 16'd302 && a < 4000) begin @(negedge clk); a++; end
        push_check("R11 flags set after matches", 3, cmp_flag);
        push_check("R12 compare 2 output toggled", (prev2 == 0) ? 1 : 0, cmp2_out);
        @(posedge clk); #1;
        flag_clr = 2'b01; cycles(1); flag_clr = 2'b00;
        @(negedge clk);
        push_check("R11 flag 1 cleared, flag 2 kept", 2, cmp_flag);

        cycles(3);
        wait (exp_q.size() == 0);
        cycles(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule